// File: doc/BRIEF.md
# Frame-Synchronous Register Bank Switch

This block keeps two full copies of the per-frame sensor settings, bank A and bank B, and hands the pixel pipeline one coherent set that changes only on frame boundaries. Software may write either bank at any moment through a byte-wide register write port. Those writes land in shadow storage. On the vertical sync pulse, the whole shadow of the selected bank is copied into the active set in a single clock edge.

A control bit picks the bank for the next frame. A status output reports which bank feeds the frame now running. An 8-bit frame counter advances on each vsync that closes a streamed frame. An optional fast-tracking flag adds the frame-end strobe as a second latch point, so a change can reach the pipeline one frame sooner.

Multi-byte fields are staged: the high byte is held aside and enters the shadow together with the low byte. A latch can therefore never pick up half of a 16-bit or 12-bit update.

Top module: `frame_bank_switch`

## Requirements
- R1: The active outputs and bank_status change only on a latch event. A latch event is a vsync pulse, or a frame_end pulse while fast tracking is on. Bank writes between latch events leave the outputs unchanged.
- R2: On a latch event, the active set is loaded from the bank named by bit 0 of control register 0x0150 (0 = bank A, 1 = bank B). It takes effect on the clock edge that samples the event.
- R3: bank_status shows the bank that supplied the current active set (0 = A, 1 = B). Writing bit 1 of 0x0150 has no effect on it.
- R4: A bank write in the same cycle as vsync is stored in the shadow but is not part of that latch. It reaches the outputs at the following latch.
- R5: Bank A starts at 0x0154 and bank B at 0x0254, each 8 bytes with the same layout. Offsets 0 and 1 hold duration and analog gain. Offsets 2 and 3 hold the high and low bytes of the 12-bit digital gain; only bits 3:0 of the high byte are kept. Offsets 4 and 5 hold coarse integration, and offsets 6 and 7 hold the data format. A high-byte write is held and enters the shadow only with the next low-byte write to that field.
- R6: frame_count is 8 bits. It rises by one on each vsync for which a frame_start pulse has occurred since the previous vsync, including the same cycle. It wraps from 0xFF to 0x00. A vsync with no frame_start leaves it unchanged, and writes to 0x0151 are ignored.
- R7: Bit 0 of 0x0152 is the fast-tracking flag. When it is 1, frame_end is a latch event but does not advance frame_count. When it is 0, frame_end has no effect.
- R8: A write to one bank never changes the other bank's contents.
- R9: After reset the active fields, bank_status, the bank select bit, the fast-tracking flag and frame_count are all zero.
- R10: Writes to addresses outside the two bank windows, 0x0150 and 0x0152 change nothing. This includes the byte just past each bank and 0x0153.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register byte address |
| wr_data | input | 8 | Register write data |
| vsync | input | 1 | Vertical sync pulse, one cycle |
| frame_start | input | 1 | Frame start strobe |
| frame_end | input | 1 | Frame end strobe |
| act_duration | output | 8 | Active frame duration |
| act_again | output | 8 | Active analog gain |
| act_dgain | output | 12 | Active digital gain |
| act_coarse | output | 16 | Active coarse integration time |
| act_format | output | 16 | Active data format code |
| bank_status | output | 1 | Bank in use for the current frame |
| frame_count | output | 8 | Frame counter |

## Verification
Two situations are the hardest to reach from the ports. One is a write that lands in the very cycle of vsync. The other is a latch that falls between the high-byte and low-byte writes of a wide field. The directed tasks drive write and vsync in one shared cycle. They also deliberately pulse vsync after only the high byte, and check that the old full value survives that latch before the low byte completes it. Counter wrap requires 256 streamed frames, produced by a loop of frame_start and vsync pulses. Frames with vsync alone confirm that the counter holds.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned DG_W   = 12;
  parameter int unsigned WIDE_W = 16;
  parameter int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_BYTES = 8;
  localparam int unsigned SEL_W = $clog2(NUM_BANKS);

  localparam logic [2:0] OFF_DUR   = 3'd0;
  localparam logic [2:0] OFF_AGAIN = 3'd1;
  localparam logic [2:0] OFF_DG_HI = 3'd2;
  localparam logic [2:0] OFF_DG_LO = 3'd3;
  localparam logic [2:0] OFF_CI_HI = 3'd4;
  localparam logic [2:0] OFF_CI_LO = 3'd5;
  localparam logic [2:0] OFF_FM_HI = 3'd6;
  localparam logic [2:0] OFF_FM_LO = 3'd7;

  typedef struct packed {
    logic [DATA_W-1:0] dur;
    logic [DATA_W-1:0] again;
    logic [DG_W-1:0]   dgain;
    logic [WIDE_W-1:0] coarse;
    logic [WIDE_W-1:0] fmt;
  } settings_t;

  function automatic logic [ADDR_W-1:0] window_offset(
      input logic [ADDR_W-1:0] addr, input logic [ADDR_W-1:0] base);
    return addr - base;
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] off);
    return off < ADDR_W'(BANK_BYTES);
  endfunction

  function automatic logic is_high_byte(input logic [2:0] off);
    return (off == OFF_DG_HI) || (off == OFF_CI_HI) || (off == OFF_FM_HI);
  endfunction
endpackage

// File: rtl/bank_shadow.sv
module bank_shadow
  import fbs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 16'h0154
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output settings_t         shadow
);
  logic [ADDR_W-1:0] off;
  logic              hit;
  logic              stage_only;
  logic [DATA_W-1:0] stg_dg, stg_ci, stg_fm;

  assign off        = window_offset(wr_addr, BASE);
  assign hit        = wr_en && in_window(off);
  assign stage_only = hit && is_high_byte(off[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      stg_dg <= '0;
      stg_ci <= '0;
      stg_fm <= '0;
    end else if (hit) begin
      case (off[2:0])
        OFF_DUR:   shadow.dur    <= wr_data;
        OFF_AGAIN: shadow.again  <= wr_data;
        OFF_DG_HI: stg_dg        <= wr_data;
        OFF_DG_LO: shadow.dgain  <= DG_W'({stg_dg, wr_data});
        OFF_CI_HI: stg_ci        <= wr_data;
        OFF_CI_LO: shadow.coarse <= WIDE_W'({stg_ci, wr_data});
        OFF_FM_HI: stg_fm        <= wr_data;
        default:   shadow.fmt    <= WIDE_W'({stg_fm, wr_data});
      endcase
    end
  end

  // R5: a high byte on its own never alters the shadow contents
  assert_stage_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_only |=> $stable(shadow));

  // R8/R10: without a hit in this window the shadow stays put
  assert_window_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(shadow));
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import fbs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0150,
  parameter int unsigned       CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit0,
  input  logic              vsync,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [SEL_W-1:0]  sel_next,
  output logic              fast_track,
  output logic              latch_evt,
  output logic [SEL_W-1:0]  status,
  output logic [CNT_W-1:0]  frame_count
);
  localparam logic [ADDR_W-1:0] FAST_ADDR = CTRL_ADDR + ADDR_W'(2);

  logic sel_hit, fast_hit, seen_start, count_inc;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign sel_hit   = wr_en && (wr_addr == CTRL_ADDR);
  assign fast_hit  = wr_en && (wr_addr == FAST_ADDR);
  assign latch_evt = vsync || (fast_track && frame_end);
  assign count_inc = vsync && (seen_start || frame_start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_next    <= '0;
      fast_track  <= 1'b0;
      status      <= '0;
      seen_start  <= 1'b0;
      frame_count <= '0;
    end else begin
      if (sel_hit)   sel_next   <= SEL_W'(wr_bit0);
      if (fast_hit)  fast_track <= wr_bit0;
      if (latch_evt) status     <= sel_next;
      if (vsync)            seen_start <= 1'b0;
      else if (frame_start) seen_start <= 1'b1;
      if (count_inc) frame_count <= bump(frame_count);
    end
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_inc |=> frame_count == $past(frame_count) + CNT_W'(1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(frame_count));

  assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(status));

  assert_status_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> status == $past(sel_next));

  // R7: with fast tracking off a frame_end pulse is not a latch point
  assert_end_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_track && !vsync) |-> !latch_evt);
endmodule

// File: rtl/frame_bank_switch.sv
module frame_bank_switch
  import fbs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BANK_A_BASE = 16'h0154,
  parameter logic [ADDR_W-1:0] BANK_STRIDE = 16'h0100,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h0150,
  parameter int unsigned       CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vsync,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [7:0]        act_duration,
  output logic [7:0]        act_again,
  output logic [11:0]       act_dgain,
  output logic [15:0]       act_coarse,
  output logic [15:0]       act_format,
  output logic              bank_status,
  output logic [CNT_W-1:0]  frame_count
);
  settings_t          shadow [NUM_BANKS];
  settings_t          active;
  logic [SEL_W-1:0]   sel_next, status;
  logic               fast_track, latch_evt;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_shadow #(
      .BASE(ADDR_W'(BANK_A_BASE + b * BANK_STRIDE))
    ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .shadow (shadow[b])
    );
  end

  bank_ctrl #(
    .CTRL_ADDR(CTRL_ADDR),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bit0    (wr_data[0]),
    .vsync      (vsync),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .sel_next   (sel_next),
    .fast_track (fast_track),
    .latch_evt  (latch_evt),
    .status     (status),
    .frame_count(frame_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         active <= '0;
    else if (latch_evt) active <= shadow[sel_next];
  end

  assign act_duration = active.dur;
  assign act_again    = active.again;
  assign act_dgain    = active.dgain;
  assign act_coarse   = active.coarse;
  assign act_format   = active.fmt;
  assign bank_status  = status[0];

  assert_active_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(active));

  // R4: a write in the latch cycle cannot alter what that latch captures
  assert_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && wr_en) |=> active == $past(shadow[sel_next]));
endmodule

// File: tb/frame_bank_switch_test.sv
module frame_bank_switch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        vsync = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic [7:0]  act_duration, act_again;
  logic [11:0] act_dgain;
  logic [15:0] act_coarse, act_format;
  logic        bank_status;
  logic [7:0]  frame_count;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  localparam logic [15:0] A = 16'h0154;
  localparam logic [15:0] B = 16'h0254;

  always #10 clk = ~clk;

  frame_bank_switch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vsync(vsync), .frame_start(frame_start), .frame_end(frame_end),
    .act_duration(act_duration), .act_again(act_again), .act_dgain(act_dgain),
    .act_coarse(act_coarse), .act_format(act_format),
    .bank_status(bank_status), .frame_count(frame_count)
  );

  function automatic logic [59:0] pack(input logic [7:0] d, input logic [7:0] g,
      input logic [11:0] dg, input logic [15:0] ci, input logic [15:0] fm);
    return {d, g, dg, ci, fm};
  endfunction

  function automatic logic [59:0] outs();
    return {act_duration, act_again, act_dgain, act_coarse, act_format};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic v, input logic s, input logic e);
    @(negedge clk); vsync = v; frame_start = s; frame_end = e;
    @(negedge clk); vsync = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
  endtask

  task automatic wr_bank(input logic [15:0] base, input logic [59:0] v);
    wr(base,      v[59:52]);
    wr(base + 1,  v[51:44]);
    wr(base + 2,  {4'h0, v[43:40]});
    wr(base + 3,  v[39:32]);
    wr(base + 4,  v[31:24]);
    wr(base + 5,  v[23:16]);
    wr(base + 6,  v[15:8]);
    wr(base + 7,  v[7:0]);
  endtask

  logic [59:0] va, vb;

  task automatic t_reset();
    chk("R9 active", {4'h0, outs()}, 64'h0);
    chk("R9 status", {63'h0, bank_status}, 64'h0);
    chk("R9 count", {56'h0, frame_count}, 64'h0);
  endtask

  task automatic t_bank_a();
    va = pack(8'h11, 8'h22, 12'h345, 16'h1234, 16'h0A0A);
    wr_bank(A, va);
    chk("R1 no latch yet", {4'h0, outs()}, 64'h0);
    pulse(1, 0, 0);
    chk("R2 bank A loaded", {4'h0, outs()}, {4'h0, va});
    chk("R3 status A", {63'h0, bank_status}, 64'h0);
    chk("R6 vsync alone holds count", {56'h0, frame_count}, 64'h0);
  endtask

  task automatic t_switch_b();
    vb = pack(8'h99, 8'h88, 12'hABC, 16'hBEEF, 16'h0808);
    wr_bank(B, vb);
    wr(16'h0150, 8'h01);
    chk("R1 select waits for vsync", {4'h0, outs()}, {4'h0, va});
    chk("R3 status before vsync", {63'h0, bank_status}, 64'h0);
    pulse(1, 0, 0);
    chk("R2 bank B loaded", {4'h0, outs()}, {4'h0, vb});
    chk("R3 status B", {63'h0, bank_status}, 64'h1);
  endtask

  task automatic t_back_a();
    wr(16'h0150, 8'h02);
    chk("R3 bit1 write ignored", {63'h0, bank_status}, 64'h1);
    pulse(1, 0, 0);
    chk("R8 bank A untouched", {4'h0, outs()}, {4'h0, va});
    chk("R3 status A again", {63'h0, bank_status}, 64'h0);
  endtask

  task automatic t_collision();
    @(negedge clk); wr_en = 1'b1; wr_addr = A; wr_data = 8'h77; vsync = 1'b1;
    @(negedge clk); wr_en = 1'b0; vsync = 1'b0;
    chk("R4 collided write not latched", {56'h0, act_duration}, 64'h11);
    pulse(1, 0, 0);
    va[59:52] = 8'h77;
    chk("R4 collided write at next vsync", {4'h0, outs()}, {4'h0, va});
  endtask

  task automatic t_staging();
    wr(A + 4, 8'hAB);
    pulse(1, 0, 0);
    chk("R5 high byte alone", {48'h0, act_coarse}, 64'h1234);
    wr(A + 5, 8'hCD);
    wr(A + 2, 8'hF6);
    wr(A + 3, 8'h01);
    pulse(1, 0, 0);
    chk("R5 coarse committed", {48'h0, act_coarse}, 64'hABCD);
    chk("R5 dgain high nibble", {52'h0, act_dgain}, 64'h601);
    va[31:16] = 16'hABCD; va[43:32] = 12'h601;
  endtask

  task automatic t_fast();
    wr(A, 8'h55);
    pulse(0, 0, 1);
    chk("R7 frame_end ignored when off", {56'h0, act_duration}, 64'h77);
    wr(16'h0152, 8'h01);
    pulse(0, 0, 1);
    chk("R7 frame_end latches when on", {56'h0, act_duration}, 64'h55);
    chk("R7 no count on frame_end", {56'h0, frame_count}, 64'h0);
    wr(16'h0152, 8'h00);
    va[59:52] = 8'h55;
  endtask

  task automatic t_outside();
    wr(A + 8, 8'hEE);
    wr(16'h0153, 8'hEE);
    wr(B + 8, 8'hEE);
    wr(16'h0000, 8'hEE);
    wr(16'h0151, 8'h40);
    pulse(1, 0, 0);
    chk("R10 bank A unchanged", {4'h0, outs()}, {4'h0, va});
    chk("R6 count write ignored", {56'h0, frame_count}, 64'h0);
    wr(16'h0150, 8'h01);
    pulse(1, 0, 0);
    chk("R10 bank B unchanged", {4'h0, outs()}, {4'h0, vb});
    wr(16'h0150, 8'h00);
    pulse(1, 0, 0);
  endtask

  task automatic t_counter();
    for (int i = 0; i < 256; i++) begin
      if (i == 7) pulse(1, 1, 0);
      else begin pulse(0, 1, 0); pulse(1, 0, 0); end
      if (i == 0)   chk("R6 first frame", {56'h0, frame_count}, 64'h01);
      if (i == 7)   chk("R6 same-cycle start", {56'h0, frame_count}, 64'h08);
      if (i == 254) chk("R6 reaches FF", {56'h0, frame_count}, 64'hFF);
      if (i == 255) chk("R6 wraps", {56'h0, frame_count}, 64'h00);
    end
    pulse(1, 0, 0);
    chk("R6 no start no count", {56'h0, frame_count}, 64'h00);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL all watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank_a();
    t_switch_b();
    t_back_a();
    t_collision();
    t_staging();
    t_fast();
    t_outside();
    t_counter();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule